// File: doc/BRIEF.md
# Serial BCD to Excess-3 Code Converter

This block turns one decimal digit, presented one bit per clock on a single input line, into its Excess-3 form. The Excess-3 form is the digit plus three. The output line carries the converted bit for the same bit position. Both streams run least significant bit first, four bits per digit. The carry of the add-three is held in a seven-state Mealy machine. Each state names a bit position and, for the middle positions, whether a carry is pending. No adder is used.

There is no start strobe. A digit begins on the first clock after reset and on every fourth clock after that, so digits are sent back to back without gaps. A synchronous active-low reset returns the machine to the first-bit state from any point, including the middle of a digit. Two build-time options are provided. The first builds the next-state and output function either as a 16-entry lookup table or as a set of logic equations; the two must behave identically. The second presents the output bit either combinationally in the same cycle as its input bit, or one clock later from a flop.

Top module: `bcdx3_serial_conv`

## Requirements
- R1: With `rst_ni` low at a rising edge, the machine enters its first-bit state. In that state an input of 0 yields an output of 1 and an input of 1 yields an output of 0. While `rst_ni` is low, the registered output reads 0.
- R2: In combinational output mode, during bit k (k = 0..3, LSB first) of a digit d (0..9), `ser_z_o` equals bit k of d+3, in the same cycle that bit k of d is on `ser_x_i`.
- R3: Digits follow one another with no idle cycle. The first input bit after reset, and every fourth bit after it, is taken as a least significant bit.
- R4: The input stream 0,0,0,0 produces the output stream 1,1,0,0.
- R5: The input stream 1,1,1,0 produces the output stream 0,1,0,1.
- R6: The table-lookup build (`USE_TABLE`=1, 16 words of {Z, next state[2:0]} addressed by {X, state[2:0]}) and the equation build (`USE_TABLE`=0) give the same output for every input sequence.
- R7: With `REG_OUT`=1, `ser_z_o` in each cycle equals the combinational result of the previous cycle. It is 0 in the first cycle after reset is released.
- R8: A reset applied partway through a digit discards the partial digit. The next input bit is converted as bit 0 of a new digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the input bit is sampled on the rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| ser_x_i | input | 1 | Serial BCD input bit, LSB first |
| ser_z_o | output | 1 | Serial Excess-3 output bit |

## Verification
All ten digits are sent back to back, in ascending order, against a bench model that adds three to an integer. This exercises every reachable transition, and between digits it shows that the four-clock framing never slips. The all-zero and the 1,1,1,0 streams are sent as named cases, because they drive the carry chain to its two extremes: no carry into the top bit, and a carry into the top bit. A long pseudo-random run of digits checks that one digit cannot leak state into the next. A reset in mid-digit, followed by a fresh digit, shows that framing restarts at the least significant bit. Three builds run side by side (table with combinational output, equations with combinational output, and equations with registered output), so each output of each build is compared against the same model on every clock.

// File: rtl/bcdx3_pkg.sv
// Shared types and the transition rules of the serial BCD to Excess-3 converter.
// Assumes: digits arrive LSB first, four bits each; codes are fixed because
// the equation build decodes the individual state bits.
package bcdx3_pkg;

    localparam int STATE_W    = 3;
    localparam int DIGIT_BITS = 4;
    localparam int ADDR_W     = STATE_W + 1;
    localparam int WORD_W     = STATE_W + 1;
    localparam int TABLE_N    = 1 << ADDR_W;

    // State names carry the bit position and the pending carry of the add-three.
    typedef enum logic [STATE_W-1:0] {
        ST_BIT0     = 3'b000,
        ST_BIT1_C0  = 3'b001,
        ST_BIT1_C1  = 3'b011,
        ST_BIT2_C0  = 3'b110,
        ST_BIT2_C1  = 3'b100,
        ST_BIT3_C0  = 3'b111,
        ST_BIT3_C1  = 3'b101,
        ST_UNUSED   = 3'b010
    } conv_state_e;

    // One step of the machine: output bit and next state.
    typedef struct packed {
        logic        z;
        conv_state_e nxt;
    } step_t;

    // Transition rules written from the meaning of each state.
    function automatic step_t rule_step(input conv_state_e s, input logic x);
        step_t r;
        case (s)
            ST_BIT0:    begin r.z = ~x; r.nxt = x ? ST_BIT1_C1 : ST_BIT1_C0; end
            ST_BIT1_C0: begin r.z = ~x; r.nxt = x ? ST_BIT2_C1 : ST_BIT2_C0; end
            ST_BIT1_C1: begin r.z =  x; r.nxt = ST_BIT2_C1;                  end
            ST_BIT2_C0: begin r.z =  x; r.nxt = ST_BIT3_C0;                  end
            ST_BIT2_C1: begin r.z = ~x; r.nxt = x ? ST_BIT3_C1 : ST_BIT3_C0; end
            ST_BIT3_C0: begin r.z =  x; r.nxt = ST_BIT0;                     end
            // x=1 here is not valid BCD; defined as a return to start with z=0.
            ST_BIT3_C1: begin r.z = ~x; r.nxt = ST_BIT0;                     end
            // Unreachable code; chosen to agree with the equation build.
            default:    begin r.z =  x; r.nxt = ST_BIT1_C1;                  end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcdx3_table_next.sv
// Next-state/output function as a 16-word lookup table addressed by
// {x, state}. Each word holds {z, next state}. The table is computed at
// elaboration from the package rules.
// Assumes: purely combinational; the state register lives outside.
module bcdx3_table_next
    import bcdx3_pkg::*;
(
    input  conv_state_e st_i,
    input  logic        x_i,
    output step_t       step_o
);

    // Builds the packed table contents, one word per address.
    function automatic logic [TABLE_N*WORD_W-1:0] build_table();
        logic [TABLE_N*WORD_W-1:0] t;
        logic [ADDR_W-1:0]         a;
        t = '0;
        for (int i = 0; i < TABLE_N; i++) begin
            a = ADDR_W'(i);
            t[i*WORD_W +: WORD_W] =
                rule_step(conv_state_e'(a[STATE_W-1:0]), a[ADDR_W-1]);
        end
        return t;
    endfunction

    localparam logic [TABLE_N*WORD_W-1:0] TABLE = build_table();

    logic [ADDR_W-1:0] addr;

    // Forms the address and reads the selected word.
    always_comb begin
        addr   = {x_i, st_i};
        step_o = step_t'(TABLE[addr*WORD_W +: WORD_W]);
    end

endmodule

// File: rtl/bcdx3_eqn_next.sv
// Next-state/output function as two-level logic equations on the state bits.
// Assumes: the state codes of bcdx3_pkg, which these equations decode.
module bcdx3_eqn_next
    import bcdx3_pkg::*;
(
    input  conv_state_e st_i,
    input  logic        x_i,
    output step_t       step_o
);

    logic q2, q1, q0;
    logic d2, d1, d0;

    // Splits the state into its bits and evaluates each equation.
    always_comb begin
        {q2, q1, q0} = st_i;
        d2 = q2 ^ q0;
        d0 = ~q0;
        d1 = (~x_i & ~q2 & ~q1 &  q0)
           | ( x_i & ~q2 & ~q0)
           | (~x_i &  q2 & ~q0)
           | ( q1  & ~q0);
        step_o.z   = ~(x_i ^ q1);
        step_o.nxt = conv_state_e'({d2, d1, d0});
    end

endmodule

// File: rtl/bcdx3_state_reg.sv
// State register of the converter with a synchronous active-low clear to the
// first-bit state.
// Assumes: rst_ni is synchronous to clk_i.
module bcdx3_state_reg
    import bcdx3_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  conv_state_e nxt_i,
    output conv_state_e st_o
);

    // Loads the next state, or the start state under reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_o <= ST_BIT0;
        else         st_o <= nxt_i;
    end

    // R1 and R8: a low reset at an edge always lands in the first-bit state.
    p_sync_clear_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (st_o == ST_BIT0));

endmodule

// File: rtl/bcdx3_serial_conv.sv
// Serial BCD to Excess-3 converter, LSB first, one bit per clock.
// USE_TABLE picks the lookup-table or equation build of the step function;
// REG_OUT picks a combinational (Mealy) or one-clock-delayed output.
// Assumes: only valid BCD digits are sent; digit framing is implied by the
// four-state-per-digit cycle that starts after reset.
module bcdx3_serial_conv
    import bcdx3_pkg::*;
#(
    parameter bit USE_TABLE = 1'b1,
    parameter bit REG_OUT   = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ser_x_i,
    output logic ser_z_o
);

    localparam int PHASE_W = (DIGIT_BITS > 1) ? $clog2(DIGIT_BITS) : 1;
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(DIGIT_BITS - 1);

    conv_state_e st_q;
    step_t       step;

    generate
        if (USE_TABLE) begin : g_table
            bcdx3_table_next u_next (
                .st_i   (st_q),
                .x_i    (ser_x_i),
                .step_o (step)
            );
        end else begin : g_eqn
            bcdx3_eqn_next u_next (
                .st_i   (st_q),
                .x_i    (ser_x_i),
                .step_o (step)
            );
        end
    endgenerate

    bcdx3_state_reg u_state (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .nxt_i  (step.nxt),
        .st_o   (st_q)
    );

    generate
        if (REG_OUT) begin : g_reg_out
            logic z_q;

            // Holds the previous cycle's output bit.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) z_q <= 1'b0;
                else         z_q <= step.z;
            end
            assign ser_z_o = z_q;

            // R7: the registered output trails the combinational result by one clock.
            p_reg_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> (ser_z_o == $past(step.z)));
        end else begin : g_comb_out
            assign ser_z_o = step.z;
        end
    endgenerate

    // Independent digit-phase counter used only to check framing.
    logic [PHASE_W-1:0] phase_q;

    // Counts bit positions within a digit from reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  phase_q <= '0;
        else if (phase_q == PHASE_LAST) phase_q <= '0;
        else                          phase_q <= phase_q + 1'b1;
    end

    // R3: every fourth bit from reset starts in the first-bit state.
    p_frame_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == '0) |-> (st_q == ST_BIT0));

    // R3: the last bit of a digit is always handled in a top-bit state.
    p_frame_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PHASE_LAST) |-> (st_q == ST_BIT3_C0 || st_q == ST_BIT3_C1));

    // R3: the spare code is never entered.
    p_no_spare_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q != ST_UNUSED);

    // R2: with no add bit and a settled carry, the output copies the input.
    p_copy_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_BIT1_C1 || st_q == ST_BIT2_C0 || st_q == ST_BIT3_C0)
            |-> (step.z == ser_x_i));

    // R3: an invalid top bit after a carry still returns to the start state.
    p_top_escape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_BIT3_C1 && ser_x_i) |=> (st_q == ST_BIT0));

endmodule

// File: tb/bcdx3_serial_conv_tb_top.sv
`timescale 1ns/1ps
module bcdx3_serial_conv_tb_top;

    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x = 1'b0;
    logic z_tab, z_eqn, z_reg;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;
    logic reg_exp = 1'b0;
    logic exp_q[$];

    always #2.5 clk = ~clk;

    bcdx3_serial_conv #(.USE_TABLE(1'b1), .REG_OUT(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ser_x_i(x), .ser_z_o(z_tab));
    bcdx3_serial_conv #(.USE_TABLE(1'b0), .REG_OUT(1'b0)) dut_eqn_i (
        .clk_i(clk), .rst_ni(rst_n), .ser_x_i(x), .ser_z_o(z_eqn));
    bcdx3_serial_conv #(.USE_TABLE(1'b0), .REG_OUT(1'b1)) dut_reg_i (
        .clk_i(clk), .rst_ni(rst_n), .ser_x_i(x), .ser_z_o(z_reg));

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Entered just after a falling edge; leaves just after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        x = 1'b0;
        @(negedge clk);
        x = 1'b1; #1;
        chk("R1", z_tab, 1'b0);
        x = 1'b0; #1;
        chk("R1", z_tab, 1'b1);
        chk("R1", z_reg, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        reg_exp = 1'b0;
        exp_q.delete();
    endtask

    // Drives one bit, compares all builds against the model, advances a clock.
    task automatic run_bit(input logic xb, input string req);
        logic e;
        e = exp_q.pop_front();
        x = xb; #1;
        chk(req, z_tab, e);
        chk("R6", z_eqn, e);
        chk("R7", z_reg, reg_exp);
        reg_exp = e;
        @(negedge clk);
    endtask

    // Reference model: add three as an integer, emit bits LSB first.
    task automatic run_digit(input int d, input string req);
        int v;
        v = d + 3;
        for (int k = 0; k < 4; k++) exp_q.push_back(((v >> k) & 1) != 0);
        for (int k = 0; k < 4; k++) run_bit(((d >> k) & 1) != 0, req);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R3 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int lfsr;
        int v;
        @(negedge clk);
        do_reset();

        // R4: all-zero input gives 1,1,0,0.
        run_digit(0, "R4");
        // R5: input 1,1,1,0 gives 0,1,0,1.
        run_digit(7, "R5");

        // R2, R3: every digit back to back in ascending order.
        for (int d = 0; d < 10; d++) run_digit(d, "R2");
        // R3: descending order, no gap.
        for (int d = 9; d >= 0; d--) run_digit(d, "R3");

        // R8: abandon digit 9 after two bits, then a fresh digit.
        v = 9 + 3;
        for (int k = 0; k < 2; k++) exp_q.push_back(((v >> k) & 1) != 0);
        run_bit(1'b1, "R2");
        run_bit(1'b0, "R2");
        do_reset();
        run_digit(4, "R8");
        run_digit(8, "R8");

        // R3: pseudo-random digit stream.
        lfsr = 32'h1234;
        for (int i = 0; i < 200; i++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            run_digit((lfsr >> 8) % 10, "R3");
        end

        finish_run();
    end

endmodule